// File: doc/BRIEF.md
# DRAM Refresh Sequencer

This block decides when rows of a DRAM array get rewritten, so that no row ages past its retention period, including rows that normal traffic never touches. It keeps its own cycle timer, walks a row pointer through the array, and emits one row-refresh command per cycle with the row index attached. It talks to the normal access path through a two-wire handshake: it raises a grant while accesses may start, and it watches a busy flag that the access path holds for as long as one access is in flight.

Two refresh cadences are selectable. In spread mode, one row is refreshed each time a slot of `PERIOD/ROWS` cycles expires, so the array is never unavailable for more than a few cycles. In burst mode, all rows are refreshed back to back once per `PERIOD`, with accesses stopped for the whole run. Separately, a self-refresh request hands refresh duties to the memory itself. The sequencer then stays silent and withholds the grant. When the request is released, a fixed exit delay must elapse before access is granted again.

Top module: `refresh_sequencer`

## Requirements
- R1: While reset is high and after the edge it is sampled on, `acc_gnt` is 1, `ref_valid` is 0, `ref_row` is 0 and `sr_on` is 0.
- R2: With `mode_sel` = 0 (spread mode) and no access in flight, `ref_valid` is high for single cycles that are exactly `PERIOD/ROWS` cycles apart.
- R3: With `mode_sel` = 1 (burst mode), `ref_valid` stays high for exactly `ROWS` consecutive cycles, and successive runs start exactly `PERIOD` cycles apart. Slot expiries between runs cause no refresh.
- R4: Each refresh cycle carries the row one above the row of the previous refresh cycle, wrapping from `ROWS-1` to 0. After reset the first refresh is row 0, and `ref_row` changes only after a refresh cycle.
- R5: `acc_gnt` is 0 in every cycle in which `ref_valid` is 1.
- R6: A refresh that comes due while `acc_busy` is 1 withdraws the grant and issues no refresh until `acc_busy` falls. The refresh is then issued in the cycle after the first edge that samples `acc_busy` low.
- R7: While `sr_req` is 1, once any access in flight has finished, `sr_on` goes to 1. For as long as it stays 1, `acc_gnt` is 0 and `ref_valid` is 0.
- R8: After `sr_req` returns to 0, `sr_on` drops and `acc_gnt` returns exactly `EXIT_DLY+1` clock edges after the last edge at which `sr_req` was still 1.
- R9: Self-refresh restarts the refresh timer. In spread mode, the first refresh after exit appears `PERIOD/ROWS + 2` cycles after the grant returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | Refresh cadence: 0 spread, 1 burst |
| sr_req | input | 1 | Level request to stay in self-refresh |
| acc_busy | input | 1 | An access is in flight on the access path |
| acc_gnt | output | 1 | Accesses may start this cycle |
| ref_valid | output | 1 | Row-refresh command valid |
| ref_row | output | $clog2(ROWS) | Row index carried by the refresh command |
| sr_on | output | 1 | Self-refresh is in effect |

## Verification
Every cycle, the assertions enforce row stepping and wrap on each refresh and the ROWS bound on any burst run. They also check that the grant is absent during refresh and during the first cycle after self-refresh ends, and that a refresh never starts right after a cycle with an access in flight. The exact cadences are shown only by the bench's timed scenarios: slot spacing in spread mode, run length and start spacing in burst mode, the exit delay, and the timer restart after self-refresh. The bench also plays random access traffic against refresh and checks that refreshes are deferred and not lost.

// File: rtl/refseq_pkg.sv
package refseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_REF,
        ST_SELF,
        ST_EXIT
    } seq_state_e;

    typedef enum logic {
        RM_SPREAD = 1'b0,
        RM_BURST  = 1'b1
    } ref_mode_e;

    typedef struct packed {
        logic pending;
        logic burst;
    } due_t;

    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/refseq_timer.sv
module refseq_timer
    import refseq_pkg::*;
#(
    parameter int unsigned ROWS   = 8,
    parameter int unsigned PERIOD = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clr,
    output logic slot_due,
    output logic period_due
);
    localparam int unsigned SLOT = PERIOD / ROWS;
    localparam int unsigned SW   = idx_w(SLOT);
    localparam int unsigned PW   = idx_w(ROWS);

    logic [SW-1:0] slot_cnt;
    logic [PW-1:0] slot_idx;

    assign slot_due   = run && (slot_cnt == SW'(SLOT - 1));
    assign period_due = slot_due && (slot_idx == PW'(ROWS - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            slot_cnt <= '0;
            slot_idx <= '0;
        end else if (run) begin
            if (slot_due) begin
                slot_cnt <= '0;
                slot_idx <= (slot_idx == PW'(ROWS - 1)) ? '0 : slot_idx + 1'b1;
            end else begin
                slot_cnt <= slot_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/refseq_rows.sv
module refseq_rows
    import refseq_pkg::*;
#(
    parameter int unsigned ROWS = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     step,
    input  logic                     burst,
    output logic [idx_w(ROWS)-1:0]   row,
    output logic                     run_done
);
    localparam int unsigned RW = idx_w(ROWS);

    logic [RW-1:0] run_cnt;

    assign run_done = step && (!burst || (run_cnt == RW'(ROWS - 1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            row     <= '0;
            run_cnt <= '0;
        end else begin
            if (step) begin
                row <= (row == RW'(ROWS - 1)) ? '0 : row + 1'b1;
            end
            if (step && burst && !run_done) begin
                run_cnt <= run_cnt + 1'b1;
            end else begin
                run_cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/refseq_ctrl.sv
module refseq_ctrl
    import refseq_pkg::*;
#(
    parameter int unsigned EXIT_DLY = 6
) (
    input  logic      clk,
    input  logic      rst,
    input  ref_mode_e mode,
    input  logic      sr_req,
    input  logic      acc_busy,
    input  logic      slot_due,
    input  logic      period_due,
    input  logic      run_done,
    output logic      acc_gnt,
    output logic      ref_valid,
    output logic      ref_burst,
    output logic      sr_on,
    output logic      tmr_run,
    output logic      tmr_clr
);
    localparam int unsigned XW = idx_w(EXIT_DLY);

    seq_state_e    state;
    due_t          due;
    logic [XW-1:0] exit_cnt;
    logic          due_now;

    assign due_now   = (mode == RM_BURST) ? period_due : slot_due;
    assign acc_gnt   = (state == ST_IDLE);
    assign ref_valid = (state == ST_REF);
    assign sr_on     = (state == ST_SELF);
    assign tmr_run   = (state == ST_IDLE) || (state == ST_DRAIN) || (state == ST_REF);
    assign tmr_clr   = (state == ST_SELF);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            due       <= '0;
            exit_cnt  <= '0;
            ref_burst <= 1'b0;
        end else begin
            if (due_now && !due.pending) begin
                due.pending <= 1'b1;
                due.burst   <= (mode == RM_BURST);
            end
            case (state)
                ST_IDLE: begin
                    if (due.pending || sr_req) state <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (!acc_busy) begin
                        if (due.pending) begin
                            state       <= ST_REF;
                            ref_burst   <= due.burst;
                            due.pending <= 1'b0;
                        end else if (sr_req) begin
                            state <= ST_SELF;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_REF: begin
                    if (run_done) state <= ST_IDLE;
                end
                ST_SELF: begin
                    due <= '0;
                    if (!sr_req) begin
                        state    <= ST_EXIT;
                        exit_cnt <= '0;
                    end
                end
                ST_EXIT: begin
                    due <= '0;
                    if (exit_cnt == XW'(EXIT_DLY - 1)) state <= ST_IDLE;
                    else exit_cnt <= exit_cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_REF_AFTER_DRAIN: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_valid) |-> !$past(acc_busy)); // R6

    AST_EXIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        $fell(sr_on) |-> !acc_gnt); // R8

endmodule

// File: rtl/refresh_sequencer.sv
module refresh_sequencer
    import refseq_pkg::*;
#(
    parameter int unsigned ROWS     = 8,
    parameter int unsigned PERIOD   = 256,
    parameter int unsigned EXIT_DLY = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   mode_sel,
    input  logic                   sr_req,
    input  logic                   acc_busy,
    output logic                   acc_gnt,
    output logic                   ref_valid,
    output logic [idx_w(ROWS)-1:0] ref_row,
    output logic                   sr_on
);
    localparam int unsigned RW = idx_w(ROWS);
    localparam int unsigned LW = idx_w(ROWS + 1);

    logic slot_due, period_due, run_done, ref_burst, tmr_run, tmr_clr;

    refseq_timer #(.ROWS(ROWS), .PERIOD(PERIOD)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .run        (tmr_run),
        .clr        (tmr_clr),
        .slot_due   (slot_due),
        .period_due (period_due)
    );

    refseq_rows #(.ROWS(ROWS)) u_rows (
        .clk      (clk),
        .rst      (rst),
        .step     (ref_valid),
        .burst    (ref_burst),
        .row      (ref_row),
        .run_done (run_done)
    );

    refseq_ctrl #(.EXIT_DLY(EXIT_DLY)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .mode       (ref_mode_e'(mode_sel)),
        .sr_req     (sr_req),
        .acc_busy   (acc_busy),
        .slot_due   (slot_due),
        .period_due (period_due),
        .run_done   (run_done),
        .acc_gnt    (acc_gnt),
        .ref_valid  (ref_valid),
        .ref_burst  (ref_burst),
        .sr_on      (sr_on),
        .tmr_run    (tmr_run),
        .tmr_clr    (tmr_clr)
    );

    // consecutive refresh cycles seen so far, for the run-length check
    logic [LW-1:0] run_len;
    always_ff @(posedge clk) begin
        if (rst) run_len <= '0;
        else     run_len <= ref_valid ? run_len + 1'b1 : '0;
    end

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
        ref_valid |=> ref_row == (($past(ref_row) == RW'(ROWS - 1)) ? '0 : RW'($past(ref_row) + 1'b1))); // R4

    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ref_valid |=> $stable(ref_row)); // R4

    AST_BURST_LEN: assert property (@(posedge clk) disable iff (rst)
        ref_valid |-> (run_len < LW'(ROWS))); // R3

    AST_GNT_REF: assert property (@(posedge clk) disable iff (rst)
        ref_valid |-> !acc_gnt); // R5

endmodule

// File: tb/test_refresh_sequencer.sv
module test_refresh_sequencer;
    localparam int ROWS     = 8;
    localparam int PERIOD   = 256;
    localparam int EXIT_DLY = 6;
    localparam int SLOT     = PERIOD / ROWS;
    localparam int RW       = $clog2(ROWS);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_sel = 1'b0;
    logic          sr_req = 1'b0;
    logic          acc_busy = 1'b0;
    logic          acc_gnt, ref_valid, sr_on;
    logic [RW-1:0] ref_row;

    int  n_chk = 0, n_bad = 0, exp_row = 0, ref_cnt = 0, cyc = 0;
    bit  mon_on = 1'b0, done = 1'b0;

    refresh_sequencer #(.ROWS(ROWS), .PERIOD(PERIOD), .EXIT_DLY(EXIT_DLY)) i_refresh_sequencer (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .sr_req(sr_req), .acc_busy(acc_busy),
        .acc_gnt(acc_gnt), .ref_valid(ref_valid), .ref_row(ref_row), .sr_on(sr_on)
    );

    always #10 clk = ~clk;

    function automatic int next_row(input int r);
        return (r + 1) % ROWS;
    endfunction

    function automatic int min_refs(input int cycles);
        return cycles / SLOT - 2;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wait_ref(input int lim, input string req);
        int n = 0;
        while (!ref_valid && n < lim) begin
            tick();
            n++;
        end
        chk(ref_valid, req, 0, 1);
    endtask

    // cycle monitor: row order, grant and busy exclusion, silent self-refresh
    always @(negedge clk) begin
        if (mon_on) begin
            if (ref_valid) begin
                chk(int'(ref_row) == exp_row, "R4 row order", int'(ref_row), exp_row);
                chk(!acc_gnt, "R5 grant low during refresh", acc_gnt, 0);
                chk(!acc_busy, "R6 refresh with access in flight", acc_busy, 0);
                exp_row = next_row(exp_row);
                ref_cnt++;
            end
            if (sr_on) chk(!ref_valid, "R7 refresh output idle in self-refresh", ref_valid, 0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n, t, run, blen, c0;
        bit inrun;
        void'($urandom(32'd20240611));

        // R1 reset state
        repeat (3) tick();
        chk(acc_gnt == 1'b1, "R1 reset grant", acc_gnt, 1);
        chk(ref_valid == 1'b0, "R1 reset ref_valid", ref_valid, 0);
        chk(ref_row == '0, "R1 reset row", int'(ref_row), 0);
        chk(sr_on == 1'b0, "R1 reset sr_on", sr_on, 0);
        rst = 1'b0;
        exp_row = 0;
        mon_on = 1'b1;

        // R2 spread cadence, R4 wrap over more than one pass
        wait_ref(SLOT + 8, "R2 first spread refresh");
        for (int k = 0; k < ROWS + 3; k++) begin
            n = 0;
            do begin tick(); n++; end while (!ref_valid && n < 2 * SLOT);
            chk(n == SLOT, "R2 spread spacing", n, SLOT);
        end

        // R6 refresh due while an access is in flight
        while (!acc_gnt) tick();
        acc_busy = 1'b1;
        n = 0;
        while (acc_gnt && n < 2 * SLOT) begin tick(); n++; end
        chk(!acc_gnt, "R6 grant withdrawn on due refresh", acc_gnt, 0);
        for (int k = 0; k < 10; k++) begin
            tick();
            chk(!ref_valid, "R6 refresh held off while busy", ref_valid, 0);
        end
        acc_busy = 1'b0;
        tick();
        chk(ref_valid, "R6 refresh one cycle after busy falls", ref_valid, 1);

        // R3 burst cadence
        tick();
        mode_sel = 1'b1;
        wait_ref(PERIOD + SLOT + 8, "R3 first burst");
        for (int k = 0; k < 2; k++) begin
            t = 0; run = 1; inrun = 1'b1;
            forever begin
                tick();
                t++;
                if (ref_valid) begin
                    if (!inrun) break;
                    run++;
                end else begin
                    inrun = 1'b0;
                end
                if (t > PERIOD + 10) break;
            end
            chk(run == ROWS, "R3 burst length", run, ROWS);
            chk(t == PERIOD, "R3 burst spacing", t, PERIOD);
        end
        mode_sel = 1'b0;

        // R7 self-refresh entry and hold
        sr_req = 1'b1;
        n = 0;
        while (!sr_on && n < ROWS + 10) begin tick(); n++; end
        chk(sr_on, "R7 self-refresh entered", sr_on, 1);
        for (int k = 0; k < 3 * SLOT; k++) begin
            tick();
            chk(!acc_gnt, "R7 grant low in self-refresh", acc_gnt, 0);
            chk(sr_on, "R7 self-refresh held", sr_on, 1);
        end

        // R8 exit delay
        sr_req = 1'b0;
        n = 0;
        do begin tick(); n++; end while (!acc_gnt && n < EXIT_DLY + 20);
        chk(n == EXIT_DLY + 1, "R8 exit delay", n, EXIT_DLY + 1);
        chk(!sr_on, "R8 sr_on dropped", sr_on, 0);

        // R9 timer restarted after exit
        n = 0;
        do begin tick(); n++; end while (!ref_valid && n < 3 * SLOT);
        chk(n == SLOT + 2, "R9 first refresh after exit", n, SLOT + 2);

        // R2 R6 random access traffic in spread mode
        c0 = ref_cnt;
        blen = 0;
        for (int k = 0; k < 3000; k++) begin
            tick();
            if (!acc_busy) begin
                if (acc_gnt && $urandom_range(3) == 0) begin
                    acc_busy = 1'b1;
                    blen = $urandom_range(5, 1);
                end
            end else begin
                blen--;
                if (blen == 0) acc_busy = 1'b0;
            end
        end
        acc_busy = 1'b0;
        chk(ref_cnt - c0 >= min_refs(3000), "R2 no refresh lost under traffic",
            ref_cnt - c0, min_refs(3000));

        repeat (4) tick();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule